// File: doc/BRIEF.md
# Fixed-Point Scaled Time Counter

This block keeps a 64-bit time value in fixed-point form. On each active tick of the reference oscillator it adds a programmable increment instead of one. The increment holds both the scale, which decides how many of the low bits are fraction, and a fine frequency trim, which is the base increment plus or minus base × ppb / 10^9. Software reads the value and turns it into nanoseconds with a plain right shift. Frequency arithmetic, shift selection and wrap tracking are left to software.

The oscillator tick can be divided by a speed-dependent prescale. The base tick period is 6.4 ns at the fastest link speed and with no link. It is ten times longer at the middle speed and a hundred times longer at the slowest speed. The suggested increments for those speeds are 0x66666666, 0x40000000 and 0x50000000, with 28, 24 and 21 fractional bits. The narrow variant uses each of these shifted right by 7. Two register layouts for the increment are available through a parameter. The wide layout uses a 31-bit increment. The narrow layout uses a 24-bit increment plus an 8-bit period field, which software normally sets to 1.

The value is read 32 bits at a time. Reading the low half also latches the high half into a shadow, so a low read followed by a high read always returns one coherent 64-bit sample. There is no back-pressure anywhere: every write and read strobe is accepted in the cycle it is high, and reads return data combinationally in that same cycle.

Top module: `fxp_time_counter`

## Requirements
- R1: After reset the time value is 0, `rd_data` is 0, and the increment register holds the `INC_RESET` parameter (wide default 0x66666666, narrow default 0x01CCCCCC).
- R2: In the wide layout (`NARROW`=0), each active tick adds `inc[30:0]` to the time value, and bit 31 of the increment register has no effect.
- R3: `link_speed` selects the prescale: 0 (fastest or no link) and 3 give one active tick per `osc_tick`, 1 gives one per 10, and 2 gives one per 100. An active tick is produced when the count of `osc_tick` pulses since the last one reaches the divisor.
- R4: A write to the increment register is used from the next cycle on. A tick in the same cycle as the write still adds the old increment, and the write never changes the accumulated time value.
- R5: In the narrow layout (`NARROW`=1), bits 23:0 are the increment and bits 31:24 are a period P. The increment is added on every P-th active tick, and P=0 stops all additions.
- R6: `clr` forces the time value to 0 on the next cycle. It also restarts the prescale count and the narrow period count, and it overrides `load_en` and any tick.
- R7: `load_en` sets the time value to `load_val` on the next cycle. It takes priority over a tick in the same cycle.
- R8: With `run_en` low, the time value and the prescale count hold, whatever `osc_tick` does.
- R9: `rd_lo_en` returns time[31:0] in the same cycle and copies time[63:32] into a shadow. `rd_hi_en` returns the shadow. If both are high, the low read wins. With neither high, `rd_data` is 0.
- R10: The time value wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Reference oscillator tick strobe |
| run_en | input | 1 | Counter enable; low freezes the count |
| link_speed | input | 2 | Prescale select (0/3 fastest, 1 middle, 2 slowest) |
| clr | input | 1 | Synchronous clear of the time value |
| inc_wr_en | input | 1 | Increment register write strobe |
| inc_wr_data | input | 32 | Increment register write data |
| load_en | input | 1 | Time value load strobe |
| load_val | input | 64 | Time value to load |
| rd_lo_en | input | 1 | Low-half read strobe; latches the high-half shadow |
| rd_hi_en | input | 1 | High-half read strobe; returns the shadow |
| rd_data | output | 32 | Read data |

## Verification
A bad increment or a bad prescale count cannot be seen directly. It shows up as a wrong time value at the next read, and the error grows with every tick after that. Because of this, each sweep point runs hundreds of oscillator cycles at every speed before it compares a full 64-bit read against an arithmetic model. A broken shadow shows up on the first split read that follows a change in the high half. The bench therefore loads a new value between a low read and a high read.

// File: rtl/fxp_time_pkg.sv
`timescale 1ns/1ps
package fxp_time_pkg;
  typedef enum logic [1:0] {
    SPD_FAST = 2'd0,
    SPD_MID  = 2'd1,
    SPD_SLOW = 2'd2,
    SPD_RSVD = 2'd3
  } speed_e;

  localparam int NARROW_FIELD_W = 24;
  localparam int PERIOD_W       = 8;
endpackage

// File: rtl/fxp_tick_prescaler.sv
`timescale 1ns/1ps
module fxp_tick_prescaler #(
  parameter int MID_DIV  = 10,
  parameter int SLOW_DIV = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run_en,
  input  logic       osc_tick,
  input  logic [1:0] link_speed,
  output logic       tick
);
  import fxp_time_pkg::*;
  localparam int CW = $clog2(SLOW_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_inc, limit;
  speed_e        spd;

  always_comb begin
    spd = speed_e'(link_speed);
    case (spd)
      SPD_MID:  limit = CW'(MID_DIV);
      SPD_SLOW: limit = CW'(SLOW_DIV);
      default:  limit = CW'(1);
    endcase
    cnt_inc = cnt_q + CW'(1);
    tick    = run_en && osc_tick && (cnt_inc >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (run_en && osc_tick) cnt_q <= tick ? '0 : cnt_inc;
  end

  // R3: divided speeds never produce back-to-back ticks
  a_r3_spaced_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (link_speed == 2'd1 || link_speed == 2'd2)) |=> !tick);
endmodule

// File: rtl/fxp_inc_unit.sv
`timescale 1ns/1ps
module fxp_inc_unit #(
  parameter int          TIME_W    = 64,
  parameter bit          NARROW    = 1'b0,
  parameter logic [31:0] INC_RESET = 32'h6666_6666
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              inc_wr_en,
  input  logic [31:0]       inc_wr_data,
  output logic              add_en,
  output logic [TIME_W-1:0] add_val
);
  import fxp_time_pkg::*;

  generate
    if (NARROW) begin : g_narrow
      logic [31:0]          incn_q;
      logic [PERIOD_W-1:0]  pcnt_q;
      logic [PERIOD_W-1:0]  period;
      logic [PERIOD_W:0]    pcnt_inc;

      assign period   = incn_q[31:32-PERIOD_W];
      assign pcnt_inc = {1'b0, pcnt_q} + (PERIOD_W+1)'(1);
      assign add_en   = tick && (period != '0) && (pcnt_inc >= {1'b0, period});
      assign add_val  = {{(TIME_W-NARROW_FIELD_W){1'b0}}, incn_q[NARROW_FIELD_W-1:0]};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          incn_q <= INC_RESET;
          pcnt_q <= '0;
        end else begin
          if (inc_wr_en) incn_q <= inc_wr_data;
          if (clr)                          pcnt_q <= '0;
          else if (tick && period != '0)    pcnt_q <= add_en ? '0 : pcnt_inc[PERIOD_W-1:0];
        end
      end

      // R5: a zero period field never produces an addition
      a_r5_zero_period_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (incn_q[31:32-PERIOD_W] == '0) |-> !add_en);
    end else begin : g_wide
      logic [30:0] incw_q;
      logic        unused_sign;

      assign unused_sign = inc_wr_data[31];
      assign add_en      = tick;
      assign add_val     = {{(TIME_W-31){1'b0}}, incw_q};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         incw_q <= INC_RESET[30:0];
        else if (inc_wr_en) incw_q <= inc_wr_data[30:0];
      end

      // R4: the increment register changes only on a write
      a_r4_inc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_wr_en |=> $stable(incw_q));
    end
  endgenerate
endmodule

// File: rtl/fxp_time_accum.sv
`timescale 1ns/1ps
module fxp_time_accum #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_en,
  input  logic [TIME_W-1:0] load_val,
  input  logic              add_en,
  input  logic [TIME_W-1:0] add_val,
  output logic [TIME_W-1:0] time_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (clr)     time_q <= '0;
    else if (load_en) time_q <= load_val;
    else if (add_en)  time_q <= time_q + add_val;
  end

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (time_q == '0));

  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !clr) |=> (time_q == $past(load_val)));

  // R2 and R10: modulo addition of the increment supplied by the increment unit
  a_r2_add_step: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !clr && !load_en) |=> (time_q == $past(time_q) + $past(add_val)));
endmodule

// File: rtl/fxp_read_snap.sv
`timescale 1ns/1ps
module fxp_read_snap #(
  parameter int TIME_W = 64,
  localparam int HALF  = TIME_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_q,
  input  logic              rd_lo_en,
  input  logic              rd_hi_en,
  output logic [HALF-1:0]   rd_data
);
  logic [HALF-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shadow_q <= '0;
    else if (rd_lo_en) shadow_q <= time_q[TIME_W-1:HALF];
  end

  always_comb begin
    if (rd_lo_en)      rd_data = time_q[HALF-1:0];
    else if (rd_hi_en) rd_data = shadow_q;
    else               rd_data = '0;
  end

  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo_en |=> $stable(shadow_q));
endmodule

// File: rtl/fxp_time_counter.sv
`timescale 1ns/1ps
module fxp_time_counter #(
  parameter int          TIME_W    = 64,
  parameter bit          NARROW    = 1'b0,
  parameter int          MID_DIV   = 10,
  parameter int          SLOW_DIV  = 100,
  parameter logic [31:0] INC_RESET = 32'h6666_6666
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  osc_tick,
  input  logic                  run_en,
  input  logic [1:0]            link_speed,
  input  logic                  clr,
  input  logic                  inc_wr_en,
  input  logic [31:0]           inc_wr_data,
  input  logic                  load_en,
  input  logic [TIME_W-1:0]     load_val,
  input  logic                  rd_lo_en,
  input  logic                  rd_hi_en,
  output logic [TIME_W/2-1:0]   rd_data
);
  logic              tick, add_en;
  logic [TIME_W-1:0] add_val, time_q;

  fxp_tick_prescaler #(.MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run_en(run_en),
    .osc_tick(osc_tick), .link_speed(link_speed), .tick(tick));

  fxp_inc_unit #(.TIME_W(TIME_W), .NARROW(NARROW), .INC_RESET(INC_RESET)) u_inc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .inc_wr_en(inc_wr_en), .inc_wr_data(inc_wr_data),
    .add_en(add_en), .add_val(add_val));

  fxp_time_accum #(.TIME_W(TIME_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_en(load_en), .load_val(load_val),
    .add_en(add_en), .add_val(add_val), .time_q(time_q));

  fxp_read_snap #(.TIME_W(TIME_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .time_q(time_q),
    .rd_lo_en(rd_lo_en), .rd_hi_en(rd_hi_en), .rd_data(rd_data));

  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr && !load_en) |=> $stable(time_q));
endmodule

// File: tb/fxp_time_counter_bench.sv
`timescale 1ns/1ps
module fxp_time_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0, run_en = 1'b1, clr = 1'b0;
  logic [1:0]  link_speed = 2'd0;
  logic        inc_wr_en = 1'b0;
  logic [31:0] inc_wr_data = '0;
  logic        load_en = 1'b0;
  logic [63:0] load_val = '0;
  logic        rd_lo_en = 1'b0, rd_hi_en = 1'b0;
  logic [31:0] rd_data, rd_data_n;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [63:0] m_t = '0, m_tn = '0;
  logic [31:0] m_inc = 32'h6666_6666, m_incn = 32'h01CC_CCCC;
  int m_pre = 0, m_pc = 0;

  always #4 clk = ~clk;

  fxp_time_counter u_fxp_time_counter (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run_en(run_en),
    .link_speed(link_speed), .clr(clr), .inc_wr_en(inc_wr_en),
    .inc_wr_data(inc_wr_data), .load_en(load_en), .load_val(load_val),
    .rd_lo_en(rd_lo_en), .rd_hi_en(rd_hi_en), .rd_data(rd_data));

  fxp_time_counter #(.NARROW(1'b1), .INC_RESET(32'h01CC_CCCC)) u_fxp_time_counter_nw (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run_en(run_en),
    .link_speed(link_speed), .clr(clr), .inc_wr_en(inc_wr_en),
    .inc_wr_data(inc_wr_data), .load_en(load_en), .load_val(load_val),
    .rd_lo_en(rd_lo_en), .rd_hi_en(rd_hi_en), .rd_data(rd_data_n));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // model of one clock edge, using the values currently driven
  task automatic model_edge();
    int div;
    bit tk;
    int p;
    tk  = 1'b0;
    div = (link_speed == 2'd1) ? 10 : (link_speed == 2'd2) ? 100 : 1;
    if (clr) begin
      m_t = '0; m_tn = '0; m_pre = 0; m_pc = 0;
    end else begin
      if (run_en && osc_tick) begin
        if (m_pre + 1 >= div) begin m_pre = 0; tk = 1'b1; end
        else m_pre++;
      end
      if (load_en) begin m_t = load_val; m_tn = load_val; end
      if (tk) begin
        if (!load_en) m_t = m_t + {33'd0, m_inc[30:0]};
        p = int'(m_incn[31:24]);
        if (p != 0) begin
          if (m_pc + 1 >= p) begin
            m_pc = 0;
            if (!load_en) m_tn = m_tn + {40'd0, m_incn[23:0]};
          end else m_pc++;
        end
      end
    end
    if (inc_wr_en) begin m_inc = inc_wr_data; m_incn = inc_wr_data; end
  endtask

  task automatic cyc(input bit o);
    osc_tick = o;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic run_osc(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic write_inc(input logic [31:0] v);
    inc_wr_en = 1'b1; inc_wr_data = v;
    cyc(1'b0);
    inc_wr_en = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1; cyc(1'b0); clr = 1'b0;
  endtask

  task automatic do_load(input logic [63:0] v);
    load_en = 1'b1; load_val = v; cyc(1'b0); load_en = 1'b0;
  endtask

  task automatic read_both(output logic [63:0] w, output logic [63:0] n);
    rd_lo_en = 1'b1; #1;
    w[31:0] = rd_data; n[31:0] = rd_data_n;
    cyc(1'b0);
    rd_lo_en = 1'b0; rd_hi_en = 1'b1; #1;
    w[63:32] = rd_data; n[63:32] = rd_data_n;
    cyc(1'b0);
    rd_hi_en = 1'b0;
  endtask

  task automatic compare(input string tag);
    logic [63:0] w, n;
    read_both(w, n);
    check({tag, " wide"}, w, m_t);
    check({tag, " narrow"}, n, m_tn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] incs [5];
    logic [63:0] w, n;
    incs[0] = 32'h6666_6666; incs[1] = 32'h4000_0000; incs[2] = 32'h5000_0000;
    incs[3] = 32'h7FFF_FFFF; incs[4] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1; check("R1 idle rd_data", {32'd0, rd_data}, 64'd0);
    compare("R1 reset time");
    run_osc(1);
    compare("R1 default increment");

    // R2/R3: sweep every speed against several increments, bit 31 included
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k++) begin
        link_speed = 2'(s);
        do_clear();
        write_inc(incs[k]);
        run_osc(250);
        compare($sformatf("R2 R3 speed=%0d inc=%h", s, incs[k]));
      end
    end

    // R3: partial prescale count is kept across a read pause
    link_speed = 2'd2; do_clear(); write_inc(32'h0000_1000);
    run_osc(99); compare("R3 slow count below divisor");
    run_osc(1);  compare("R3 slow count reaches divisor");

    // R4: write coinciding with a tick uses the old increment
    link_speed = 2'd0; do_clear(); write_inc(32'h0000_0010);
    run_osc(3);
    inc_wr_en = 1'b1; inc_wr_data = 32'h0100_0100;
    cyc(1'b1);
    inc_wr_en = 1'b0;
    compare("R4 write during tick");
    run_osc(4); compare("R4 new increment after write");

    // R5: narrow period field values
    do_clear(); write_inc(32'h0300_0100); run_osc(10); compare("R5 period three");
    do_clear(); write_inc(32'h00FF_FFFF); run_osc(20); compare("R5 period zero idle");
    do_clear(); write_inc(32'h01CC_CCCC); run_osc(17); compare("R5 period one");

    // R6: clear overrides load and restarts prescale
    link_speed = 2'd1; write_inc(32'h0000_0100); run_osc(7);
    clr = 1'b1; load_en = 1'b1; load_val = 64'h1234_5678_9ABC_DEF0;
    cyc(1'b1);
    clr = 1'b0; load_en = 1'b0;
    compare("R6 clear beats load");
    run_osc(9); compare("R6 prescale restarted");

    // R7: load beats a simultaneous tick
    link_speed = 2'd0;
    load_en = 1'b1; load_val = 64'hA5A5_0000_0000_1000;
    cyc(1'b1);
    load_en = 1'b0;
    compare("R7 load over tick");
    run_osc(2); compare("R7 counting after load");

    // R8: freeze
    run_en = 1'b0; run_osc(40); compare("R8 frozen"); run_en = 1'b1;
    run_osc(1); compare("R8 resumed");

    // R10: wrap
    write_inc(32'h0000_0020); do_load(64'hFFFF_FFFF_FFFF_FFF0);
    run_osc(1); compare("R10 wrap");

    // R9: shadow holds after the time changes, low wins, idle gives zero
    do_load(64'h1111_2222_3333_4444);
    rd_lo_en = 1'b1; #1; check("R9 low half", {32'd0, rd_data}, 64'h3333_4444);
    cyc(1'b0); rd_lo_en = 1'b0;
    do_load(64'h9999_8888_7777_6666);
    rd_hi_en = 1'b1; #1; check("R9 shadow keeps old high", {32'd0, rd_data}, 64'h1111_2222);
    rd_lo_en = 1'b1; #1; check("R9 low wins", {32'd0, rd_data}, 64'h7777_6666);
    cyc(1'b0); rd_lo_en = 1'b0; #1;
    check("R9 high after new low read", {32'd0, rd_data}, 64'h9999_8888);
    rd_hi_en = 1'b0; #1;
    check("R9 idle zero", {32'd0, rd_data}, 64'd0);
    read_both(w, n);
    check("R9 coherent read", w, 64'h9999_8888_7777_6666);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule